// File: doc/BRIEF.md
# Work-Gated Divided Clock Controller

This block sits between a tile's free-running ring oscillator and the tile's processing core. It divides the oscillator clock by a programmable ratio between 1 and 128 and presents the result to the core as a gated clock. When the tile runs out of work it stops that clock. A tile is out of work when its input queue reports empty or its output path reports full. The clock does not stop at once: the core first receives a fixed number of further clock edges so that its pipeline can drain. Work that returns brings the clock back within one oscillator period.

Gating is glitch-free. The enable for the core clock is captured by a level-sensitive latch that is open only while the oscillator clock is low. Each core clock pulse is therefore either a full oscillator high phase or absent. The controller also registers the ring-length selection for the oscillator, short or long ring, and hands it back out. All control inputs are taken as synchronous to the oscillator clock.

Top module: `clkhalt_ctrl`

## Requirements
- R1: `div_sel_i` holds k, with 0 to 127 meaning divide by 1 to 128. While no stall is present, consecutive rising edges of `core_clk_o` are exactly k+1 oscillator cycles apart.
- R2: `div_sel_i` is sampled only on an oscillator edge that is also a core clock edge. A change in mid-period leaves the current period unchanged and sets the length of the next period.
- R3: Every core clock pulse covers the full high phase of one oscillator cycle. `core_clk_o` is low throughout every oscillator low phase, so no shortened pulse appears.
- R4: The stall condition is `fifo_empty_i` OR `out_full_i`, sampled at core clock edges. Once the stall has been seen at 9 consecutive core clock edges, with the first of them included, no further core clock edge occurs.
- R5: A stall that is absent at any oscillator edge during the countdown clears it. The clock keeps running, and a later stall needs a full 9 core edges again before it halts.
- R6: If the stall is absent at an oscillator edge while the clock is halted, the next oscillator edge after that one is a core clock edge. After that, periods follow `div_sel_i` again.
- R7: While the clock is halted, `core_clk_o` stays low.
- R8: While `rst_ni` is low, `core_clk_o` follows the oscillator at divide-by-1 and the clock is not halted. The first oscillator edge after release is a core clock edge, and that edge loads the ratio.
- R9: `ring_long_o` (0 = short ring, 1 = long ring) equals `ring_long_i` delayed by one oscillator cycle. It is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Raw oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | 7 | Divide ratio minus one |
| fifo_empty_i | input | 1 | Input queue empty, no work |
| out_full_i | input | 1 | Output path full, cannot send |
| ring_long_i | input | 1 | Requested ring length, 1 = long |
| ring_long_o | output | 1 | Registered ring length for the oscillator |
| core_clk_o | output | 1 | Gated, divided core clock |

## Verification
A reference model runs beside the design and predicts the presence of a core pulse for every oscillator cycle. The ratios tried are 1, 4, 5, 3 and 128, which separate an off-by-one reload from a correct one at both ends of the range. Ratios are also changed in mid-period, which exposes any reload that happens outside the boundary. The bench drives stalls from each source separately. Some stalls last long enough to halt, which checks the exact drain count of 9 edges. Others drop out for a single cycle during the countdown, which separates a reset countdown from one that is merely paused. Every cycle is also sampled inside the high phase and again in the low phase, so a pulse that is chopped short or stretched shows up.

// File: rtl/clkhalt_pkg.sv
`timescale 1ns/1ps
package clkhalt_pkg;
   // Ring length code handed to the oscillator
   typedef enum logic {
      RING_SHORT = 1'b0,
      RING_LONG  = 1'b1
   } ring_len_e;

   // Gating element variants
   typedef enum logic {
      GATE_FLOP  = 1'b0,
      GATE_LATCH = 1'b1
   } gate_style_e;
endpackage

// File: rtl/clkhalt_divider.sv
`timescale 1ns/1ps
// Down-counting divider; tick marks an oscillator edge that is a core edge.
module clkhalt_divider #(
   parameter int DIV_W = 7
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hold_i,
   input  logic [DIV_W-1:0] ratio_i,
   output logic             tick_o
);
   logic [DIV_W-1:0] cnt_q;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16)
         else $error("clkhalt_divider: DIV_W out of range");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (hold_i) begin
         // parked on a boundary so wake-up is immediate
         cnt_q <= '0;
      end else if (cnt_q == '0) begin
         // ratio read only here: boundary load
         cnt_q <= ratio_i;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign tick_o = (cnt_q == '0);

   // R6
   hold_parks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i |=> tick_o);

   // R1
   div_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && !hold_i && ratio_i == '0) |=> tick_o);

   // R2
   mid_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && !hold_i && ratio_i != '0) |=> !tick_o);
endmodule

// File: rtl/clkhalt_drain.sv
`timescale 1ns/1ps
// Counts stalled core edges and raises halt after the drain window.
module clkhalt_drain #(
   parameter int DRAIN_CYCLES = 9
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic stall_i,
   output logic halted_o
);
   localparam int CW = $clog2(DRAIN_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(DRAIN_CYCLES - 1);

   logic [CW-1:0] drn_q;
   logic          halt_q;

   initial begin
      assert (DRAIN_CYCLES >= 1)
         else $error("clkhalt_drain: DRAIN_CYCLES must be positive");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         drn_q  <= '0;
         halt_q <= 1'b0;
      end else if (!stall_i) begin
         // work present: cancel countdown and release halt
         drn_q  <= '0;
         halt_q <= 1'b0;
      end else if (tick_i && !halt_q) begin
         if (drn_q == LAST) begin
            halt_q <= 1'b1;
            drn_q  <= '0;
         end else begin
            drn_q <= drn_q + 1'b1;
         end
      end
   end

   assign halted_o = halt_q;

   // R4
   halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(halted_o) |-> $past(stall_i && tick_i));

   // R6
   wake_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (halted_o && !stall_i) |=> !halted_o);

   // R4
   drain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drn_q < CW'(DRAIN_CYCLES));

   // R5
   cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stall_i |=> (drn_q == '0));
endmodule

// File: rtl/clkhalt_gate.sv
`timescale 1ns/1ps
// Glitch-free clock gate: enable captured while the clock is low.
module clkhalt_gate
   import clkhalt_pkg::*;
#(
   parameter gate_style_e STYLE = GATE_LATCH
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   output logic gclk_o
);
   logic en_q;

   generate
      if (STYLE == GATE_LATCH) begin : g_latch
         // transparent in the low phase, frozen in the high phase
         always_latch begin
            if (!clk_i) en_q = en_i;
         end
      end else begin : g_flop
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) en_q <= 1'b1;
            else         en_q <= en_i;
         end
      end
   endgenerate

   assign gclk_o = clk_i & en_q;
endmodule

// File: rtl/clkhalt_ctrl.sv
`timescale 1ns/1ps
module clkhalt_ctrl
   import clkhalt_pkg::*;
#(
   parameter int          DIV_W        = 7,
   parameter int          DRAIN_CYCLES = 9,
   parameter gate_style_e GATE         = GATE_LATCH,
   parameter ring_len_e   RING_RESET   = RING_SHORT
) (
   input  logic             osc_clk_i,
   input  logic             rst_ni,
   input  logic [DIV_W-1:0] div_sel_i,
   input  logic             fifo_empty_i,
   input  logic             out_full_i,
   input  logic             ring_long_i,
   output logic             ring_long_o,
   output logic             core_clk_o
);
   logic stall;
   logic tick;
   logic halted;
   logic gate_en;
   logic ring_q;

   assign stall = fifo_empty_i | out_full_i;

   clkhalt_divider #(.DIV_W(DIV_W)) u_div (
      .clk_i   (osc_clk_i),
      .rst_ni  (rst_ni),
      .hold_i  (halted),
      .ratio_i (div_sel_i),
      .tick_o  (tick)
   );

   clkhalt_drain #(.DRAIN_CYCLES(DRAIN_CYCLES)) u_drain (
      .clk_i    (osc_clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .stall_i  (stall),
      .halted_o (halted)
   );

   assign gate_en = tick & ~halted;

   clkhalt_gate #(.STYLE(GATE)) u_gate (
      .clk_i  (osc_clk_i),
      .rst_ni (rst_ni),
      .en_i   (gate_en),
      .gclk_o (core_clk_o)
   );

   always_ff @(posedge osc_clk_i or negedge rst_ni) begin
      if (!rst_ni) ring_q <= RING_RESET;
      else         ring_q <= ring_long_i;
   end
   assign ring_long_o = ring_q;

   // R9
   ring_follow_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
      $past(rst_ni) |-> (ring_long_o == $past(ring_long_i)));

   // R7
   halt_quiet_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
      (halted && stall) |=> !gate_en);
endmodule

// File: tb/tb_clkhalt_ctrl.sv
`timescale 1ns/1ps
module tb_clkhalt_ctrl;
   localparam int DRAIN = 9;

   logic       osc_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] div_sel = 7'd0;
   logic       fifo_empty = 1'b0;
   logic       out_full = 1'b0;
   logic       ring_in = 1'b1;
   logic       ring_out;
   logic       core_clk;

   int n_chk = 0;
   int n_fail = 0;
   string cur_req = "R8";

   logic  exp_q[$];
   string tag_q[$];

   int m_wait = 0;
   int m_hcnt = 0;
   bit m_halt = 1'b0;
   bit m_wake = 1'b0;

   always #4 osc_clk = ~osc_clk;

   clkhalt_ctrl dut (
      .osc_clk_i    (osc_clk),
      .rst_ni       (rst_n),
      .div_sel_i    (div_sel),
      .fifo_empty_i (fifo_empty),
      .out_full_i   (out_full),
      .ring_long_i  (ring_in),
      .ring_long_o  (ring_out),
      .core_clk_o   (core_clk)
   );

   function automatic void chk(bit ok, string req, logic act, logic expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, expv);
      end
   endfunction

   // Reference model: expected core pulse per oscillator cycle
   always @(posedge osc_clk) begin : model
      logic  e;
      string t;
      bit    st;
      st = fifo_empty | out_full;
      t  = cur_req;
      if (!rst_n) begin
         e = 1'b1; m_wait = 0; m_hcnt = 0; m_halt = 1'b0; m_wake = 1'b0; t = "R8";
      end else if (m_halt) begin
         e = 1'b0; t = "R7";
         if (!st) begin
            m_halt = 1'b0; m_wait = 0; m_wake = 1'b1; t = "R6";
         end
      end else if (m_wait == 0) begin
         e = 1'b1;
         if (m_wake) t = "R6";
         m_wake = 1'b0;
         m_wait = int'(div_sel);
         if (st) begin
            if (m_hcnt == DRAIN - 1) begin
               m_halt = 1'b1; m_hcnt = 0;
            end else m_hcnt++;
         end else m_hcnt = 0;
      end else begin
         e = 1'b0;
         m_wait--;
         if (!st) m_hcnt = 0;
      end
      exp_q.push_back(e);
      tag_q.push_back(t);
   end

   // Monitor: pops predictions and compares at high and low phase
   always begin : monitor
      logic  e;
      string t;
      @(posedge osc_clk);
      #1;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(core_clk === e, t, core_clk, e);
         #2;
         chk(core_clk === e, "R3", core_clk, e);
         #2;
         chk(core_clk === 1'b0, "R3", core_clk, 1'b0);
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge osc_clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin : watchdog
      #(200000 * 8);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin : driver
      // R8 / R9: reset state
      cycles(3);
      chk(ring_out === 1'b0, "R9", ring_out, 1'b0);
      cycles(3);
      rst_n = 1'b1;
      cur_req = "R1";
      cycles(10);
      // R9: ring select follows one cycle later
      ring_in = 1'b1;
      @(posedge osc_clk); #1;
      chk(ring_out === 1'b1, "R9", ring_out, 1'b1);
      @(negedge osc_clk);
      ring_in = 1'b0;
      @(posedge osc_clk); #1;
      chk(ring_out === 1'b0, "R9", ring_out, 1'b0);
      // R1: several ratios
      div_sel = 7'd3;   cycles(40);
      div_sel = 7'd127; cycles(400);
      div_sel = 7'd4;   cycles(30);
      // R2: mid-period changes
      cur_req = "R2";
      div_sel = 7'd5;   cycles(2);
      div_sel = 7'd2;   cycles(3);
      div_sel = 7'd6;   cycles(4);
      div_sel = 7'd2;   cycles(20);
      // R4: stall from empty queue, ratio 3
      cur_req = "R4";
      fifo_empty = 1'b1; cycles(60);
      // R6: work returns
      fifo_empty = 1'b0; cycles(20);
      // R5: stall cancelled by a one-cycle gap, then full halt
      cur_req = "R5";
      out_full = 1'b1;  cycles(12);
      out_full = 1'b0;  cycles(1);
      out_full = 1'b1;  cycles(45);
      out_full = 1'b0;  cycles(10);
      // R4 at divide-by-1 through the output-full source
      cur_req = "R4";
      div_sel = 7'd0;
      out_full = 1'b1;  cycles(20);
      out_full = 1'b0;  cycles(6);
      fifo_empty = 1'b1; cycles(4);
      fifo_empty = 1'b0; cycles(1);
      fifo_empty = 1'b1; cycles(15);
      fifo_empty = 1'b0; cycles(8);
      // R6 at maximum ratio: wake comes fast regardless
      div_sel = 7'd127;
      fifo_empty = 1'b1; cycles(1400);
      fifo_empty = 1'b0; cycles(300);
      cycles(2);
      summary();
   end
endmodule